// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block keeps the control state of three outgoing message buffers of a bus controller and decides which of them goes onto the bus next. Each buffer holds a request flag, a 2-bit priority and a set of outcome flags: aborted, lost arbitration, transmit error and transmit done. Requests arrive in two ways. Software can write a buffer's control word. Each buffer also has an active-low request pin whose falling edge, once that pin is configured for request use, marks the buffer as pending.

When the bus reports idle and no transmission is in flight, the block compares the pending buffers. It hands the winner's index to the framer and holds it while the frame is on the bus. The framer then returns one of three results: success, error during transmission, or lost arbitration. The block updates the buffer's flags from that result and drives a single interrupt output from the enabled flags.

An abort-all control aborts every buffer that is not already on the bus. It stays in force until software clears it.

Top module: `txq_sched`

## Requirements
- R1: After reset all request, abort, lost-arbitration, error and done flags are 0. The message-error flag, `tx_busy` and `irq` are 0. Pin request use is disabled. `pin_state` reads all ones.
- R2: A write with `wr_req`=1 to a buffer that is not in flight sets its request flag at the next edge. The same write clears that buffer's abort, lost-arbitration and error flags and loads `wr_prio`. A write with `wr_req`=0 to a buffer that is not in flight clears the request without setting its abort flag.
- R3: A transmission starts at an edge where all of the following hold before the edge: `bus_idle`=1, `tx_busy`=0, abort-all clear, and at least one request set. `tx_busy` then reads 1 with `tx_idx` naming the winner. `tx_busy` stays 1 until a nonzero `tx_result` arrives.
- R4: The winner is the pending buffer with the largest priority value. Value 3 is the highest level and value 0 the lowest.
- R5: Among pending buffers of equal priority, the one with the larger index wins.
- R6: `tx_result`=1 (success) while busy clears the in-flight buffer's request, sets its done flag and ends the transmission.
- R7: `tx_result`=2 (error) while busy keeps the request set, sets the buffer's error flag and the message-error flag, and ends the transmission.
- R8: `tx_result`=3 (lost arbitration) while busy keeps the request set, sets the buffer's lost-arbitration flag and ends the transmission.
- R9: `irq` = OR over buffers of (done flag AND `ie_tx` bit) OR (message-error flag AND `ie_merr`). `txif_clr` and `merr_clr` clear the flags at the next edge, and a new set wins over a clear in the same cycle.
- R10: `pin_state` is `rts_n` delayed through two flip-flops. When a buffer's pin-use bit is 1, a falling pin level applied before edge k sets that buffer's request at edge k+2 (visible after it).
- R11: `pcfg_we` loads the pin-use bits from `pcfg_val` only while `cfg_mode`=1. Otherwise the write is ignored, and a pin whose bit is 0 never sets a request.
- R12: Writes to the buffer in flight, including the buffer being started at that edge, are ignored. Its request stays set until a result arrives.
- R13: While abort-all is set (`abort_we` loads `abort_val`), every buffer that is not in flight and has a request gets its request cleared and its abort flag set at the next edge. No new transmission starts while abort-all is set.
- R14: A register write and a pin falling edge on the same buffer in the same cycle leave the request set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Configuration mode; pin-use writes accepted only here |
| wr_en | input | 1 | Control-word write strobe |
| wr_buf | input | 2 | Buffer addressed by the write |
| wr_req | input | 1 | Request value written |
| wr_prio | input | 2 | Priority written |
| abort_we | input | 1 | Abort-all register write strobe |
| abort_val | input | 1 | Abort-all value written |
| pcfg_we | input | 1 | Pin-use register write strobe |
| pcfg_val | input | 3 | Pin-use bits written (1 = request use) |
| rts_n | input | 3 | Active-low request pins |
| bus_idle | input | 1 | Bus is free for a new frame |
| tx_result | input | 2 | Framer outcome: 0 none, 1 success, 2 error, 3 lost arbitration |
| txif_clr | input | 3 | Clear per-buffer done flags |
| merr_clr | input | 1 | Clear message-error flag |
| ie_tx | input | 3 | Per-buffer done interrupt enables |
| ie_merr | input | 1 | Message-error interrupt enable |
| pin_state | output | 3 | Synchronized pin levels |
| req_o | output | 3 | Request flags |
| abtf_o | output | 3 | Abort flags |
| mloa_o | output | 3 | Lost-arbitration flags |
| txerr_o | output | 3 | Transmit-error flags |
| txif_o | output | 3 | Transmit-done flags |
| merrf_o | output | 1 | Message-error flag |
| tx_busy | output | 1 | A buffer is on the bus |
| tx_idx | output | 2 | Index of the buffer on the bus |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall on one buffer in a single cycle. A software write may meet the pin edge that requests the same buffer. A write that clears a request may meet the edge at which that buffer is picked or is already on the bus. The bench provokes the first case by timing a write to land on the edge where the synchronized pin falls, and the second by clearing the in-flight buffer in the cycle after start. Random stimulus also makes both cases collide with results and with abort-all. Every cycle is judged against a bench model built from the requirements: a request set always wins over a same-cycle clear, and the buffer in flight keeps its request until the framer reports a result.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_OK   = 2'd1,
    RES_ERR  = 2'd2,
    RES_LOST = 2'd3
  } txq_res_e;
endpackage

// File: rtl/txq_pin_sync.sv
module txq_pin_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_n,
  output logic [N-1:0] level,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= pins_n[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign level[g] = s2_q;
    assign fall[g]  = s3_q & ~s2_q;

    // R10
    fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall[g] |=> !fall[g]);
  end
endmodule

// File: rtl/txq_arbiter.sv
module txq_arbiter #(
  parameter int N  = 3,
  parameter int PW = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    pend,
  input  logic [N*PW-1:0] prio,
  output logic            any,
  output logic [IW-1:0]   sel
);
  logic [PW-1:0] best;

  always_comb begin
    any  = 1'b0;
    sel  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (!any || prio[i*PW +: PW] >= best)) begin
        any  = 1'b1;
        best = prio[i*PW +: PW];
        sel  = IW'(i);
      end
    end
  end

  // R4
  always_comb begin
    if (any) begin
      sel_pending_chk: assert (pend[sel]);
    end
  end
endmodule

// File: rtl/txq_buf_ctrl.sv
module txq_buf_ctrl #(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inflight,
  input  logic          set_req,
  input  logic          clr_req,
  input  logic          prio_we,
  input  logic [PW-1:0] wr_prio,
  input  logic          abort_all,
  input  logic          res_ok,
  input  logic          res_err,
  input  logic          res_lost,
  input  logic          txif_clr,
  output logic          req_q,
  output logic [PW-1:0] prio_q,
  output logic          abtf_q,
  output logic          mloa_q,
  output logic          txerr_q,
  output logic          txif_q
);
  logic          req_d, abtf_d, mloa_d, txerr_d, txif_d;
  logic [PW-1:0] prio_d;

  always_comb begin
    req_d   = req_q;
    abtf_d  = abtf_q;
    mloa_d  = mloa_q;
    txerr_d = txerr_q;
    prio_d  = prio_we ? wr_prio : prio_q;
    if (set_req) begin
      req_d   = 1'b1;
      abtf_d  = 1'b0;
      mloa_d  = 1'b0;
      txerr_d = 1'b0;
    end else if (clr_req) begin
      req_d = 1'b0;
    end
    if (abort_all && !inflight && req_d) begin
      req_d  = 1'b0;
      abtf_d = 1'b1;
    end
    if (res_ok)   req_d   = 1'b0;
    if (res_err)  txerr_d = 1'b1;
    if (res_lost) mloa_d  = 1'b1;
    txif_d = (txif_q & ~txif_clr) | res_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      prio_q  <= '0;
      abtf_q  <= 1'b0;
      mloa_q  <= 1'b0;
      txerr_q <= 1'b0;
      txif_q  <= 1'b0;
    end else begin
      req_q   <= req_d;
      prio_q  <= prio_d;
      abtf_q  <= abtf_d;
      mloa_q  <= mloa_d;
      txerr_q <= txerr_d;
      txif_q  <= txif_d;
    end
  end

  // R2
  set_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req && !abort_all |=> req_q && !abtf_q && !mloa_q && !txerr_q);
  // R6
  res_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ok |=> !req_q && txif_q);
  // R7
  res_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |=> req_q && txerr_q);
  // R8
  res_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_lost |=> req_q && mloa_q);
  // R13
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_all && !inflight |=> !req_q);
endmodule

// File: rtl/txq_sched.sv
module txq_sched
  import txq_pkg::*;
#(
  parameter int NBUF = 3,
  parameter int PW   = 2,
  localparam int IW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_mode,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_buf,
  input  logic            wr_req,
  input  logic [PW-1:0]   wr_prio,
  input  logic            abort_we,
  input  logic            abort_val,
  input  logic            pcfg_we,
  input  logic [NBUF-1:0] pcfg_val,
  input  logic [NBUF-1:0] rts_n,
  input  logic            bus_idle,
  input  logic [1:0]      tx_result,
  input  logic [NBUF-1:0] txif_clr,
  input  logic            merr_clr,
  input  logic [NBUF-1:0] ie_tx,
  input  logic            ie_merr,
  output logic [NBUF-1:0] pin_state,
  output logic [NBUF-1:0] req_o,
  output logic [NBUF-1:0] abtf_o,
  output logic [NBUF-1:0] mloa_o,
  output logic [NBUF-1:0] txerr_o,
  output logic [NBUF-1:0] txif_o,
  output logic            merrf_o,
  output logic            tx_busy,
  output logic [IW-1:0]   tx_idx,
  output logic            irq
);
  txq_res_e          res;
  logic [NBUF-1:0]   fall;
  logic [NBUF-1:0]   pcfg_q, pcfg_d;
  logic              abort_q, abort_d;
  logic              busy_q, busy_d;
  logic [IW-1:0]     cur_q, cur_d;
  logic              merr_q, merr_d;
  logic              any_pend, start;
  logic [IW-1:0]     win;
  logic [NBUF*PW-1:0] prio_flat;
  logic [NBUF-1:0]   err_hit;

  assign res = txq_res_e'(tx_result);

  txq_pin_sync #(.N(NBUF)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_n (rts_n),
    .level  (pin_state),
    .fall   (fall)
  );

  txq_arbiter #(.N(NBUF), .PW(PW)) u_arb (
    .pend (req_o),
    .prio (prio_flat),
    .any  (any_pend),
    .sel  (win)
  );

  assign start = bus_idle && !busy_q && any_pend && !abort_q;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic          mine, inflight, hit;
    logic [PW-1:0] prio_g;

    assign mine     = busy_q && (cur_q == IW'(g));
    assign inflight = mine || (start && (win == IW'(g)));
    assign hit      = wr_en && (wr_buf == IW'(g));
    assign err_hit[g] = mine && (res == RES_ERR);

    txq_buf_ctrl #(.PW(PW)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .inflight  (inflight),
      .set_req   (!inflight && ((hit && wr_req) || (pcfg_q[g] && fall[g]))),
      .clr_req   (!inflight && hit && !wr_req),
      .prio_we   (!inflight && hit),
      .wr_prio   (wr_prio),
      .abort_all (abort_q),
      .res_ok    (mine && (res == RES_OK)),
      .res_err   (err_hit[g]),
      .res_lost  (mine && (res == RES_LOST)),
      .txif_clr  (txif_clr[g]),
      .req_q     (req_o[g]),
      .prio_q    (prio_g),
      .abtf_q    (abtf_o[g]),
      .mloa_q    (mloa_o[g]),
      .txerr_q   (txerr_o[g]),
      .txif_q    (txif_o[g])
    );

    assign prio_flat[g*PW +: PW] = prio_g;
  end

  always_comb begin
    pcfg_d  = (pcfg_we && cfg_mode) ? pcfg_val : pcfg_q;
    abort_d = abort_we ? abort_val : abort_q;
    merr_d  = (merr_q && !merr_clr) || (|err_hit);
    busy_d  = busy_q;
    cur_d   = cur_q;
    if (start) begin
      busy_d = 1'b1;
      cur_d  = win;
    end else if (busy_q && res != RES_NONE) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcfg_q  <= '0;
      abort_q <= 1'b0;
      busy_q  <= 1'b0;
      cur_q   <= '0;
      merr_q  <= 1'b0;
    end else begin
      pcfg_q  <= pcfg_d;
      abort_q <= abort_d;
      busy_q  <= busy_d;
      cur_q   <= cur_d;
      merr_q  <= merr_d;
    end
  end

  assign tx_busy = busy_q;
  assign tx_idx  = cur_q;
  assign merrf_o = merr_q;
  assign irq     = (|(txif_o & ie_tx)) || (merr_q && ie_merr);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && res == RES_NONE |=> busy_q);
  // R12
  inflight_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> req_o[cur_q]);
  // R13
  no_start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q && !busy_q |=> !busy_q);
  // R11
  pcfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> pcfg_q == $past(pcfg_q));
endmodule

// File: tb/test_txq_sched.sv
`timescale 1ns/1ps
module test_txq_sched;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_mode, wr_en, wr_req, abort_we, abort_val, pcfg_we;
  logic [1:0] wr_buf, wr_prio, tx_result;
  logic [2:0] pcfg_val, rts_n, txif_clr, ie_tx;
  logic       bus_idle, merr_clr, ie_merr;
  logic [2:0] pin_state, req_o, abtf_o, mloa_o, txerr_o, txif_o;
  logic       merrf_o, tx_busy, irq;
  logic [1:0] tx_idx;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic [2:0] m_req, m_abtf, m_mloa, m_txerr, m_txif, m_pcfg, s1, s2, s3;
  logic [1:0] m_prio [3];
  logic       m_busy, m_merr, m_abort;
  logic [1:0] m_cur;
  logic [2:0] n_req, n_abtf, n_mloa, n_txerr, n_txif, n_pcfg;
  logic [1:0] n_prio [3];
  logic       n_busy, n_merr, n_abort;
  logic [1:0] n_cur;

  always #2 clk = ~clk;

  txq_sched i_txq_sched (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_en(wr_en),
    .wr_buf(wr_buf), .wr_req(wr_req), .wr_prio(wr_prio),
    .abort_we(abort_we), .abort_val(abort_val), .pcfg_we(pcfg_we),
    .pcfg_val(pcfg_val), .rts_n(rts_n), .bus_idle(bus_idle),
    .tx_result(tx_result), .txif_clr(txif_clr), .merr_clr(merr_clr),
    .ie_tx(ie_tx), .ie_merr(ie_merr), .pin_state(pin_state),
    .req_o(req_o), .abtf_o(abtf_o), .mloa_o(mloa_o), .txerr_o(txerr_o),
    .txif_o(txif_o), .merrf_o(merrf_o), .tx_busy(tx_busy),
    .tx_idx(tx_idx), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // highest priority value wins, ties go to the larger index (R4, R5)
  function automatic logic [2:0] pick();
    logic [2:0] r = 3'b0;
    logic [1:0] bp = 2'd0;
    for (int i = 0; i < 3; i++)
      if (m_req[i] && (!r[2] || m_prio[i] >= bp)) begin
        r = {1'b1, 2'(i)};
        bp = m_prio[i];
      end
    return r;
  endfunction

  task automatic model_reset();
    m_req = '0; m_abtf = '0; m_mloa = '0; m_txerr = '0; m_txif = '0;
    m_pcfg = '0; s1 = '1; s2 = '1; s3 = '1;
    m_busy = 0; m_merr = 0; m_abort = 0; m_cur = '0;
    for (int i = 0; i < 3; i++) m_prio[i] = '0;
  endtask

  task automatic model_next();
    logic [2:0] w = pick();
    logic st = bus_idle && !m_busy && w[2] && !m_abort;
    n_req = m_req; n_abtf = m_abtf; n_mloa = m_mloa; n_txerr = m_txerr;
    n_merr = (m_merr && !merr_clr);
    n_txif = m_txif & ~txif_clr;
    for (int i = 0; i < 3; i++) begin
      logic mine = m_busy && m_cur == 2'(i);
      logic infl = mine || (st && w[1:0] == 2'(i));
      logic hit = wr_en && wr_buf == 2'(i);
      logic set = !infl && ((hit && wr_req) || (m_pcfg[i] && s3[i] && !s2[i]));
      n_prio[i] = (hit && !infl) ? wr_prio : m_prio[i];
      if (set) begin
        n_req[i] = 1; n_abtf[i] = 0; n_mloa[i] = 0; n_txerr[i] = 0;
      end else if (!infl && hit && !wr_req) n_req[i] = 0;
      if (m_abort && !infl && n_req[i]) begin n_req[i] = 0; n_abtf[i] = 1; end
      if (mine && tx_result == 2'd1) begin n_req[i] = 0; n_txif[i] = 1; end
      if (mine && tx_result == 2'd2) begin n_txerr[i] = 1; n_merr = 1; end
      if (mine && tx_result == 2'd3) n_mloa[i] = 1;
    end
    n_busy = m_busy; n_cur = m_cur;
    if (st) begin n_busy = 1; n_cur = w[1:0]; end
    else if (m_busy && tx_result != 2'd0) n_busy = 0;
    n_abort = abort_we ? abort_val : m_abort;
    n_pcfg = (pcfg_we && cfg_mode) ? pcfg_val : m_pcfg;
  endtask

  task automatic step();
    model_next();
    @(posedge clk); #1;
    m_req = n_req; m_abtf = n_abtf; m_mloa = n_mloa; m_txerr = n_txerr;
    m_txif = n_txif; m_merr = n_merr; m_busy = n_busy; m_cur = n_cur;
    m_abort = n_abort; m_pcfg = n_pcfg;
    for (int i = 0; i < 3; i++) m_prio[i] = n_prio[i];
    s3 = s2; s2 = s1; s1 = rts_n;
    chk("R2 request flags", 8'(req_o), 8'(m_req));
    chk("R13 abort flags", 8'(abtf_o), 8'(m_abtf));
    chk("R8 lost flags", 8'(mloa_o), 8'(m_mloa));
    chk("R7 error flags", {4'(txerr_o), 3'b0, merrf_o}, {4'(m_txerr), 3'b0, m_merr});
    chk("R6 done flags", 8'(txif_o), 8'(m_txif));
    chk("R3 busy", 8'(tx_busy), 8'(m_busy));
    if (m_busy) chk("R4 index", 8'(tx_idx), 8'(m_cur));
    chk("R10 pin state", 8'(pin_state), 8'(s2));
    chk("R9 irq", 8'(irq), 8'((|(m_txif & ie_tx)) || (m_merr && ie_merr)));
  endtask

  task automatic wr(input logic [1:0] b, input logic r, input logic [1:0] p);
    wr_en = 1; wr_buf = b; wr_req = r; wr_prio = p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 0; cfg_mode = 0; wr_en = 0; wr_req = 0; abort_we = 0; abort_val = 0;
    pcfg_we = 0; wr_buf = 0; wr_prio = 0; tx_result = 0; pcfg_val = 0;
    rts_n = '1; txif_clr = 0; ie_tx = 0; bus_idle = 0; merr_clr = 0; ie_merr = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 reset req", 8'(req_o), 8'h0);
    chk("R1 reset flags", 8'({abtf_o, mloa_o}), 8'h0);
    chk("R1 reset busy/irq", {5'b0, tx_busy, merrf_o, irq}, 8'h0);
    chk("R1 reset pins", 8'(pin_state), 8'h7);

    // R4 priority selection
    wr(0, 1, 3); step(); wr(1, 1, 1); step(); wr(2, 1, 2); step();
    wr_en = 0; bus_idle = 1; step();
    chk("R4 highest priority", {7'b0, tx_busy}, 8'h1);
    chk("R4 winner index", 8'(tx_idx), 8'h0);
    bus_idle = 0; tx_result = 1; step(); tx_result = 0;
    chk("R6 success", {4'b0, 1'b0, req_o[0], txif_o[0], tx_busy}, 8'h2);

    // R5 tie, R12 in-flight clear, R7 error, R8 lost
    wr(1, 1, 2); step(); wr_en = 0; bus_idle = 1; step();
    chk("R5 tie to larger index", 8'(tx_idx), 8'h2);
    bus_idle = 0; wr(2, 0, 0); step(); wr_en = 0;
    chk("R12 in-flight clear ignored", 8'(req_o[2]), 8'h1);
    tx_result = 2; step(); tx_result = 0;
    chk("R7 error result", {5'b0, req_o[2], txerr_o[2], merrf_o}, 8'h7);
    bus_idle = 1; step(); bus_idle = 0;
    chk("R5 tie again", 8'(tx_idx), 8'h2);
    tx_result = 3; step(); tx_result = 0;
    chk("R8 lost result", {6'b0, req_o[2], mloa_o[2]}, 8'h3);
    wr(2, 1, 2); step();
    chk("R2 set clears flags", {6'b0, mloa_o[2], txerr_o[2]}, 8'h0);
    wr(1, 0, 2); step(); wr_en = 0;
    chk("R2 single clear no abort flag", {6'b0, req_o[1], abtf_o[1]}, 8'h0);

    // R13 abort-all
    abort_we = 1; abort_val = 1; step(); abort_we = 0; step();
    chk("R13 abort-all", {6'b0, req_o[2], abtf_o[2]}, 8'h1);
    bus_idle = 1; step();
    chk("R13 no start", 8'(tx_busy), 8'h0);
    wr(0, 1, 1); step(); wr_en = 0;
    chk("R13 sticky", {6'b0, req_o[0], abtf_o[0]}, 8'h1);
    abort_we = 1; abort_val = 0; step(); abort_we = 0; bus_idle = 0;

    // R11 locked config, R10 pin request
    pcfg_we = 1; pcfg_val = 3'b111; step(); pcfg_we = 0;
    rts_n = 3'b110; repeat (4) step();
    chk("R11 pin config locked", 8'(req_o[0]), 8'h0);
    rts_n = 3'b111; repeat (3) step();
    cfg_mode = 1; pcfg_we = 1; step(); pcfg_we = 0; cfg_mode = 0;
    rts_n = 3'b101; step(); step();
    chk("R10 before sync delay", 8'(req_o[1]), 8'h0);
    step();
    chk("R10 pin request", 8'(req_o[1]), 8'h1);

    // R14 write and pin edge together
    rts_n = 3'b111; repeat (3) step();
    rts_n = 3'b110; step(); step();
    wr(0, 1, 1); step(); wr_en = 0;
    chk("R14 write with pin edge", 8'(req_o[0]), 8'h1);

    // R9 interrupts
    ie_tx = 3'b111; step();
    chk("R9 done irq", 8'(irq), 8'h1);
    txif_clr = 3'b111; merr_clr = 1; step(); txif_clr = 0; merr_clr = 0;
    ie_merr = 1; step();
    chk("R9 cleared irq", 8'(irq), 8'h0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      wr_en = ($urandom_range(0, 3) == 0);
      wr_buf = 2'($urandom_range(0, 2));
      wr_req = ($urandom_range(0, 3) != 0);
      wr_prio = 2'($urandom);
      bus_idle = ($urandom_range(0, 2) == 0);
      tx_result = m_busy && ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      cfg_mode = ($urandom_range(0, 9) == 0);
      pcfg_we = ($urandom_range(0, 9) == 0);
      pcfg_val = 3'($urandom);
      abort_we = ($urandom_range(0, 29) == 0);
      abort_val = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 5) == 0) rts_n[$urandom_range(0, 2)] ^= 1'b1;
      txif_clr = ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'b0;
      merr_clr = ($urandom_range(0, 6) == 0);
      ie_tx = 3'($urandom);
      ie_merr = 1'($urandom);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule